// File: doc/BRIEF.md
# Four-channel peripheral DMA controller

This block moves data between memory buffers and fixed peripheral data registers without processor involvement. Each of its channels owns a register set holding a peripheral address, a memory address, a unit count and a control word. Once a channel is enabled and the peripheral request line it selects goes high, the controller repeatedly moves single data units over a simple request/acknowledge memory bus until the count is used up.

Every unit is a bus read from the source followed by a bus write of the same data to the destination. Between units a priority arbiter picks the next channel from those with work pending. A channel in normal mode stops at the end of its block and raises a sticky completion flag. A channel in circular mode restores its start addresses and count and carries on without stopping.

Top module: `perdma_top`

## Requirements
- R1: After reset, bus_req, every bit of done and every bit of periph_ack are low.
- R2: Configuration writes use cfg_addr = {channel, register}, with register 0 the peripheral address, 1 the memory address, 2 the unit count and 3 the control word. A channel moves data only when control bit 0 (enable) is set, its count is non-zero and the periph_req line chosen by control bits 10:9 is high. Every other request line is ignored by that channel.
- R3: A unit is one read followed by one write. Each step holds bus_req, bus_addr and bus_we steady until bus_ack. The written data equals the data read.
- R4: When control bit 1 is 1, the read goes to the memory address and the write goes to the peripheral address. When it is 0, the read goes to the peripheral address and the write goes to the memory address.
- R5: Control bit 2 enables peripheral-address increment and bit 3 enables memory-address increment, each applied separately after every unit. The step is set by the size code in bits 5:4: code 0 steps 1 byte, code 1 steps 2 bytes, and codes 2 and 3 step 4 bytes. bus_size carries the size code during both bus steps.
- R6: Among pending channels, the one with the larger priority value in control bits 8:7 is served first.
- R7: Among pending channels with equal priority, the lower channel number is served first.
- R8: Arbitration is repeated before every unit, so a higher-priority channel that becomes pending during another channel's block gets the next unit.
- R9: In normal mode (control bit 6 = 0), a channel stops after its programmed number of units, even with its request still high. Its done bit then rises and stays set until that channel's done_clr bit is pulsed.
- R10: In circular mode (control bit 6 = 1), after the last unit the channel reloads its start addresses and count and continues. Its done bit stays low.
- R11: periph_ack pulses high for one cycle on the bit of the served channel, in the cycle after each unit's write is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IW+2 | {channel, register} write address |
| cfg_wdata | input | CFGW | Configuration write data |
| done_clr | input | NCH | Per-channel completion flag clear |
| periph_req | input | NSRC | Peripheral request lines |
| periph_ack | output | NCH | Per-channel unit-complete pulse |
| done | output | NCH | Per-channel sticky completion flag |
| bus_req | output | 1 | Bus request |
| bus_we | output | 1 | Bus write (1) or read (0) |
| bus_addr | output | AW | Bus byte address |
| bus_wdata | output | DW | Bus write data |
| bus_size | output | 2 | Unit size code of the current access |
| bus_ack | input | 1 | Bus acknowledge |
| bus_rdata | input | DW | Bus read data, valid with bus_ack |

## Verification
The bench uses the default parameters: four channels, four request lines, 16-bit addresses and counts, and 32-bit data. Four channels with a separate request line each make every priority-versus-channel-number ordering reachable from a single change of the request lines. Four lines against a 2-bit selector let the bench raise a source that a channel does not select. Small counts keep normal and circular blocks short enough that the bench can follow every address across a circular wrap. The bench also varies the bus wait states to exercise the hold-until-acknowledge behaviour.

// File: rtl/perdma_pkg.sv
package perdma_pkg;

  typedef enum logic [1:0] {
    REG_PADDR = 2'd0,
    REG_MADDR = 2'd1,
    REG_COUNT = 2'd2,
    REG_CTRL  = 2'd3
  } reg_sel_e;

  // control word, bit 0 is the enable
  typedef struct packed {
    logic [1:0] src_sel;  // 10:9
    logic [1:0] prio;     // 8:7
    logic       circ;     // 6
    logic [1:0] usize;    // 5:4
    logic       minc;     // 3
    logic       pinc;     // 2
    logic       m2p;      // 1
    logic       en;       // 0
  } chan_ctrl_t;

  localparam int CTRL_W = $bits(chan_ctrl_t);

  typedef enum logic [1:0] {
    ENG_IDLE  = 2'd0,
    ENG_READ  = 2'd1,
    ENG_WRITE = 2'd2
  } eng_state_e;

  // bytes covered by one unit for a size code
  function automatic logic [2:0] unit_bytes(input logic [1:0] usize);
    case (usize)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

endpackage

// File: rtl/perdma_chan.sv
module perdma_chan
  import perdma_pkg::*;
#(
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int NSRC = 4,
  parameter int CFGW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_reg,
  input  logic [CFGW-1:0] wr_data,
  input  logic [NSRC-1:0] src_req,
  input  logic            unit_done,
  input  logic            done_clr,
  output logic            pend,
  output logic [1:0]      prio,
  output logic [1:0]      usize,
  output logic [AW-1:0]   rd_addr,
  output logic [AW-1:0]   wr_addr,
  output logic            done
);

  logic [AW-1:0] base_p, base_m, cur_p, cur_m;
  logic [CW-1:0] reload_cnt, cnt;
  chan_ctrl_t    ctl;
  logic          done_q;
  logic [3:0]    req_pad;
  logic          last_unit;
  logic          sel_req;

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a,
                                              input logic inc,
                                              input logic [1:0] usz);
    return inc ? a + AW'(unit_bytes(usz)) : a;
  endfunction

  generate
    if (NSRC >= 4) begin : g_full
      assign req_pad = src_req[3:0];
    end else begin : g_pad
      assign req_pad = {{(4-NSRC){1'b0}}, src_req};
    end
  endgenerate

  assign sel_req   = req_pad[ctl.src_sel];
  assign last_unit = unit_done && (cnt == CW'(1));
  assign pend      = ctl.en && (cnt != '0) && sel_req;
  assign prio      = ctl.prio;
  assign usize     = ctl.usize;
  assign rd_addr   = ctl.m2p ? cur_m : cur_p;
  assign wr_addr   = ctl.m2p ? cur_p : cur_m;
  assign done      = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_p     <= '0;
      base_m     <= '0;
      cur_p      <= '0;
      cur_m      <= '0;
      reload_cnt <= '0;
      cnt        <= '0;
      ctl        <= '0;
      done_q     <= 1'b0;
    end else begin
      if (unit_done) begin
        if (last_unit && ctl.circ) begin
          cur_p <= base_p;
          cur_m <= base_m;
          cnt   <= reload_cnt;
        end else begin
          cur_p <= step_addr(cur_p, ctl.pinc, ctl.usize);
          cur_m <= step_addr(cur_m, ctl.minc, ctl.usize);
          cnt   <= cnt - CW'(1);
        end
      end
      if (wr_en) begin
        case (reg_sel_e'(wr_reg))
          REG_PADDR: begin
            base_p <= wr_data[AW-1:0];
            cur_p  <= wr_data[AW-1:0];
          end
          REG_MADDR: begin
            base_m <= wr_data[AW-1:0];
            cur_m  <= wr_data[AW-1:0];
          end
          REG_COUNT: begin
            reload_cnt <= wr_data[CW-1:0];
            cnt        <= wr_data[CW-1:0];
          end
          default: ctl <= chan_ctrl_t'(wr_data[CTRL_W-1:0]);
        endcase
      end
      if (done_clr) done_q <= 1'b0;
      if (last_unit && !ctl.circ) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/perdma_arb.sv
module perdma_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0]   pend,
  input  logic [2*NCH-1:0] prio_flat,
  output logic             any,
  output logic [IW-1:0]    win
);

  // highest priority wins; scanning downward with >= lets the lower index take ties
  function automatic logic [IW-1:0] pick(input logic [NCH-1:0] p,
                                         input logic [2*NCH-1:0] pr);
    logic [1:0]    best;
    logic [IW-1:0] idx;
    best = 2'd0;
    idx  = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (p[i] && (pr[2*i +: 2] >= best)) begin
        best = pr[2*i +: 2];
        idx  = IW'(i);
      end
    end
    return idx;
  endfunction

  assign any = |pend;
  assign win = pick(pend, prio_flat);

endmodule

// File: rtl/perdma_eng.sv
module perdma_eng
  import perdma_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arb_any,
  input  logic [IW-1:0] arb_win,
  input  logic [AW-1:0] cand_raddr,
  input  logic [AW-1:0] cand_waddr,
  input  logic [1:0]    cand_size,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  output logic [1:0]    bus_size,
  output logic          unit_done,
  output logic [IW-1:0] grant_idx
);

  eng_state_e    st;
  logic [AW-1:0] raddr_q, waddr_q;
  logic [1:0]    size_q;
  logic [DW-1:0] dbuf;
  logic [IW-1:0] gidx;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= ENG_IDLE;
      raddr_q <= '0;
      waddr_q <= '0;
      size_q  <= '0;
      dbuf    <= '0;
      gidx    <= '0;
    end else begin
      case (st)
        ENG_IDLE: if (arb_any) begin
          gidx    <= arb_win;
          raddr_q <= cand_raddr;
          waddr_q <= cand_waddr;
          size_q  <= cand_size;
          st      <= ENG_READ;
        end
        ENG_READ: if (bus_ack) begin
          dbuf <= bus_rdata;
          st   <= ENG_WRITE;
        end
        ENG_WRITE: if (bus_ack) st <= ENG_IDLE;
        default: st <= ENG_IDLE;
      endcase
    end
  end

  assign bus_req   = (st == ENG_READ) || (st == ENG_WRITE);
  assign bus_we    = (st == ENG_WRITE);
  assign bus_addr  = (st == ENG_WRITE) ? waddr_q : raddr_q;
  assign bus_wdata = dbuf;
  assign bus_size  = size_q;
  assign unit_done = (st == ENG_WRITE) && bus_ack;
  assign grant_idx = gidx;

endmodule

// File: rtl/perdma_top.sv
module perdma_top
  import perdma_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int NSRC = 4,
  parameter int AW   = 16,
  parameter int CW   = 16,
  parameter int DW   = 32,
  localparam int IW  = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int CFGW = (AW > CW) ? ((AW > CTRL_W) ? AW : CTRL_W)
                                  : ((CW > CTRL_W) ? CW : CTRL_W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_we,
  input  logic [IW+1:0]   cfg_addr,
  input  logic [CFGW-1:0] cfg_wdata,
  input  logic [NCH-1:0]  done_clr,
  input  logic [NSRC-1:0] periph_req,
  output logic [NCH-1:0]  periph_ack,
  output logic [NCH-1:0]  done,
  output logic            bus_req,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  output logic [1:0]      bus_size,
  input  logic            bus_ack,
  input  logic [DW-1:0]   bus_rdata
);

  logic [NCH-1:0]   pend_vec;
  logic [2*NCH-1:0] prio_flat;
  logic [1:0]       ch_size [NCH];
  logic [AW-1:0]    ch_rd   [NCH];
  logic [AW-1:0]    ch_wr   [NCH];
  logic             arb_any;
  logic [IW-1:0]    arb_win;
  logic             unit_done;
  logic [IW-1:0]    grant_idx;
  logic [IW-1:0]    cfg_ch;
  logic [1:0]       cfg_reg;

  assign cfg_ch  = cfg_addr[IW+1:2];
  assign cfg_reg = cfg_addr[1:0];

  generate
    for (genvar i = 0; i < NCH; i++) begin : g_ch
      logic wr_sel;
      logic [1:0] pr;
      assign wr_sel = cfg_we && (cfg_ch == IW'(i));
      assign prio_flat[2*i +: 2] = pr;
      perdma_chan #(.AW(AW), .CW(CW), .NSRC(NSRC), .CFGW(CFGW)) u_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_sel),
        .wr_reg    (cfg_reg),
        .wr_data   (cfg_wdata),
        .src_req   (periph_req),
        .unit_done (unit_done && (grant_idx == IW'(i))),
        .done_clr  (done_clr[i]),
        .pend      (pend_vec[i]),
        .prio      (pr),
        .usize     (ch_size[i]),
        .rd_addr   (ch_rd[i]),
        .wr_addr   (ch_wr[i]),
        .done      (done[i])
      );
    end
  endgenerate

  perdma_arb #(.NCH(NCH), .IW(IW)) u_arb (
    .pend      (pend_vec),
    .prio_flat (prio_flat),
    .any       (arb_any),
    .win       (arb_win)
  );

  perdma_eng #(.AW(AW), .DW(DW), .IW(IW)) u_eng (
    .clk        (clk),
    .rst_n      (rst_n),
    .arb_any    (arb_any),
    .arb_win    (arb_win),
    .cand_raddr (ch_rd[arb_win]),
    .cand_waddr (ch_wr[arb_win]),
    .cand_size  (ch_size[arb_win]),
    .bus_ack    (bus_ack),
    .bus_rdata  (bus_rdata),
    .bus_req    (bus_req),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_size   (bus_size),
    .unit_done  (unit_done),
    .grant_idx  (grant_idx)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) periph_ack <= '0;
    else        periph_ack <= unit_done ? (NCH'(1) << grant_idx) : '0;
  end

endmodule

// File: rtl/perdma_chk.sv
module perdma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_req,
  input logic           bus_we,
  input logic           bus_ack,
  input logic [AW-1:0]  bus_addr,
  input logic [DW-1:0]  bus_wdata,
  input logic [DW-1:0]  bus_rdata,
  input logic [NCH-1:0] pend_vec,
  input logic [NCH-1:0] periph_ack,
  input logic [NCH-1:0] done,
  input logic [NCH-1:0] done_clr
);

  assert_hold_until_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we)));

  assert_write_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack) |=> (bus_req && bus_we));

  assert_wdata_from_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_we && bus_ack) |=> (bus_wdata == $past(bus_rdata)));

  assert_no_idle_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_req && (pend_vec == '0)) |=> !bus_req);

  assert_ack_onehot_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(periph_ack));

  assert_ack_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (|periph_ack) |-> $past(bus_req && bus_we && bus_ack));

  assert_done_rise_with_ack_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((done & ~$past(done) & ~periph_ack) == '0));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(done) & ~$past(done_clr) & ~done) == '0));

endmodule

bind perdma_top perdma_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .bus_req    (bus_req),
  .bus_we     (bus_we),
  .bus_ack    (bus_ack),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .bus_rdata  (bus_rdata),
  .pend_vec   (pend_vec),
  .periph_ack (periph_ack),
  .done       (done),
  .done_clr   (done_clr)
);

// File: tb/sim_perdma_top.sv
`timescale 1ns/1ps
module sim_perdma_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  done_clr = '0;
  logic [3:0]  periph_req = '0;
  logic [3:0]  periph_ack;
  logic [3:0]  done;
  logic        bus_req, bus_we;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [1:0]  bus_size;
  logic        bus_ack = 1'b0;
  logic [31:0] bus_rdata = '0;

  always #2 clk = ~clk;

  perdma_top u0 (.*);

  int n_chk = 0, n_fail = 0, cyc = 0;
  int wait_n = 0, wcnt = 0, nlog = 0, nack = 0;
  logic        lg_we   [64];
  logic [15:0] lg_addr [64];
  logic [31:0] lg_data [64];
  logic [1:0]  lg_size [64];
  int          ack_ord [16];

  function automatic logic [31:0] mem_val(input logic [15:0] a);
    return {a ^ 16'h5A3C, a};
  endfunction

  function automatic logic [15:0] mk_ctrl(input logic en, m2p, pinc, minc,
                                          input logic [1:0] usz, input logic circ,
                                          input logic [1:0] prio, src);
    return {5'd0, src, prio, circ, usz, minc, pinc, m2p, en};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int rg, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = {2'(ch), 2'(rg)}; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic clear_done(input int ch);
    @(negedge clk); done_clr[ch] = 1'b1;
    @(negedge clk); done_clr = '0;
  endtask

  // bus responder with programmable wait states; logs each accepted access
  always @(negedge clk) begin
    if (!rst_n) begin
      bus_ack = 1'b0; wcnt = 0;
    end else if (bus_ack) begin
      bus_ack = 1'b0;
    end else if (bus_req) begin
      if (wcnt >= wait_n) begin
        wcnt = 0;
        bus_ack = 1'b1;
        bus_rdata = mem_val(bus_addr);
        if (nlog < 64) begin
          lg_we[nlog] = bus_we; lg_addr[nlog] = bus_addr;
          lg_data[nlog] = bus_wdata; lg_size[nlog] = bus_size;
        end
        nlog++;
      end else wcnt++;
    end
  end

  always @(negedge clk) begin
    if (rst_n && (|periph_ack)) begin
      for (int i = 0; i < 4; i++)
        if (periph_ack[i] && nack < 16) ack_ord[nack] = i;
      nack++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0]  ch;
    logic [1:0]  src;
    logic        m2p;
    logic        pinc;
    logic        minc;
    logic [1:0]  usz;
    logic        circ;
    logic [7:0]  cnt;
    logic [15:0] pa;
    logic [15:0] ma;
    logic [7:0]  units;
    logic [1:0]  waitn;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{2'd0, 2'd0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 8'd4, 16'h4000, 16'h1000, 8'd4, 2'd0},
    '{2'd1, 2'd3, 1'b0, 1'b0, 1'b1, 2'd2, 1'b0, 8'd3, 16'h4010, 16'h2000, 8'd3, 2'd2},
    '{2'd2, 2'd1, 1'b1, 1'b1, 1'b1, 2'd1, 1'b0, 8'd2, 16'h4100, 16'h3000, 8'd2, 2'd1},
    '{2'd3, 2'd2, 1'b0, 1'b1, 1'b0, 2'd1, 1'b1, 8'd3, 16'h5000, 16'h3800, 8'd7, 2'd0}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 bus_req after reset", 32'(bus_req), 0);
    chk("R1 done after reset", 32'(done), 0);
    chk("R1 periph_ack after reset", 32'(periph_ack), 0);

    // table-driven single-channel blocks: R3 R4 R5 R9 R10 R11
    for (int r = 0; r < 4; r++) begin
      row_t t;
      int step, kk;
      logic [15:0] pk, mk, ra, wa;
      t = ROWS[r];
      wait_n = int'(t.waitn); nlog = 0; nack = 0;
      cfg(t.ch, 0, t.pa);
      cfg(t.ch, 1, t.ma);
      cfg(t.ch, 2, 16'(t.cnt));
      cfg(t.ch, 3, mk_ctrl(1'b1, t.m2p, t.pinc, t.minc, t.usz, t.circ, 2'd0, t.src));
      @(negedge clk); periph_req[t.src] = 1'b1;
      wait (nlog == 2 * int'(t.units));
      if (t.circ) periph_req[t.src] = 1'b0;
      repeat (12) @(negedge clk);
      step = (t.usz == 2'd0) ? 1 : (t.usz == 2'd1) ? 2 : 4;
      for (int k = 0; k < int'(t.units); k++) begin
        kk = t.circ ? (k % int'(t.cnt)) : k;
        pk = t.pa + (t.pinc ? 16'(kk * step) : 16'd0);
        mk = t.ma + (t.minc ? 16'(kk * step) : 16'd0);
        ra = t.m2p ? mk : pk;
        wa = t.m2p ? pk : mk;
        chk($sformatf("R4 R5 R10 row%0d unit%0d read", r, k),
            {13'd0, lg_we[2*k], lg_size[2*k], lg_addr[2*k]}, {13'd0, 1'b0, t.usz, ra});
        chk($sformatf("R3 R4 R5 row%0d unit%0d write addr", r, k),
            {13'd0, lg_we[2*k+1], lg_size[2*k+1], lg_addr[2*k+1]}, {13'd0, 1'b1, t.usz, wa});
        chk($sformatf("R3 row%0d unit%0d write data", r, k), lg_data[2*k+1], mem_val(ra));
      end
      chk($sformatf("R11 row%0d ack pulses", r), 32'(nack), 32'(t.units));
      chk($sformatf("R9 R10 row%0d no extra access", r), 32'(nlog), 32'(2 * int'(t.units)));
      if (!t.circ) begin
        chk($sformatf("R9 row%0d done set", r), 32'(done[t.ch]), 1);
        periph_req = '0;
        repeat (3) @(negedge clk);
        chk($sformatf("R9 row%0d done held", r), 32'(done[t.ch]), 1);
        clear_done(t.ch);
        chk($sformatf("R9 row%0d done cleared", r), 32'(done[t.ch]), 0);
      end else begin
        chk("R10 circular keeps done low", 32'(done[t.ch]), 0);
        cfg(t.ch, 3, 16'd0);
      end
    end

    // r2_ disabled channel and unselected source
    wait_n = 0; nlog = 0; nack = 0;
    cfg(1, 0, 16'h4200); cfg(1, 1, 16'h2200); cfg(1, 2, 16'd2);
    cfg(1, 3, mk_ctrl(1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 2'd2));
    periph_req = 4'b0100;
    repeat (20) @(negedge clk);
    chk("R2 disabled channel idle", 32'(nlog), 0);
    periph_req = 4'b1011;
    cfg(1, 3, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 2'd2));
    repeat (20) @(negedge clk);
    chk("R2 other sources ignored", 32'(nlog), 0);
    periph_req = 4'b0100;
    wait (done[1] == 1'b1);
    repeat (4) @(negedge clk);
    chk("R2 selected source starts block", 32'(nlog), 4);
    periph_req = '0;
    clear_done(1);

    // r6_ r7_ priority then channel number
    nack = 0;
    for (int c = 0; c < 4; c++) begin
      cfg(c, 0, 16'h4000 + 16'(c)); cfg(c, 1, 16'h1000 + 16'(c * 16)); cfg(c, 2, 16'd1);
      cfg(c, 3, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, (c >= 2) ? 2'd3 : 2'd1, 2'(c)));
    end
    @(negedge clk); periph_req = 4'hF;
    wait (nack == 4);
    chk("R6 highest priority first", 32'(ack_ord[0]), 2);
    chk("R7 tie at top level to lower channel", 32'(ack_ord[1]), 3);
    chk("R6 R7 low level lower channel first", 32'(ack_ord[2]), 0);
    chk("R7 last served", 32'(ack_ord[3]), 1);
    periph_req = '0;
    for (int c = 0; c < 4; c++) clear_done(c);

    // r8_ re-arbitration between units
    nack = 0;
    cfg(0, 2, 16'd4);
    cfg(0, 3, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd0, 2'd0));
    cfg(3, 2, 16'd1);
    cfg(3, 3, mk_ctrl(1'b1, 1'b1, 1'b0, 1'b1, 2'd0, 1'b0, 2'd2, 2'd3));
    @(negedge clk); periph_req = 4'b0001;
    wait (nack == 1);
    periph_req[3] = 1'b1;
    wait (nack == 5);
    chk("R8 first unit ch0", 32'(ack_ord[0]), 0);
    chk("R8 late high priority takes next unit", 32'(ack_ord[1]), 3);
    chk("R8 ch0 resumes", 32'(ack_ord[2]), 0);
    chk("R8 ch0 finishes", 32'(ack_ord[4]), 0);
    repeat (4) @(negedge clk);
    chk("R9 both normal channels done", 32'(done), 32'h9);
    periph_req = '0;

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule